// File: doc/BRIEF.md
# Half-Bridge PWM Generator with Dead-Band Delay

This block drives the two switches of a half-bridge power stage from one pulse-width setting. An internal period timer counts from zero up to a programmed period value and then starts again. Each pass of the timer is one PWM cycle. The primary drive is active while the timer is below the duty value. The complementary drive is active for the rest of the cycle. Both drives are active-high.

Each drive has its own delay counter. A drive may turn on only after its condition has held for a programmed number of clock cycles, the dead-band count. This keeps one switch off until the other has had time to turn off. If a drive's window is no longer than the dead-band count, that drive never turns on during the cycle. The dead-band count is 7 bits by default.

The period, duty and dead-band inputs pass through shadow registers. The shadows load only at the end of a cycle, or continuously while the block is disabled, so a change made partway through a cycle takes effect at the next cycle boundary. Dropping the enable clears both drives and both delay counters.

Top module: `hbridge_pwm`

## Requirements
- R1: While reset is asserted and after it is released, both drives are low until the block is enabled.
- R2: While enabled, the timer counts 0, 1, …, P and then returns to 0, where P is the shadow period value. A PWM cycle is therefore P+1 clock cycles long.
- R3: The primary condition holds for timer values below the shadow duty D. When D is 0 the condition never holds. When D ≥ P it holds for the whole cycle.
- R4: The complementary condition is the logical inverse of the primary condition. Each drive goes low on the clock edge after its condition ends.
- R5: With dead-band count N, a drive goes high N+1 clock cycles after its condition begins: one register stage plus N counted cycles. It stays high while the condition holds.
- R6: A drive whose condition lasts N cycles or fewer stays low for that whole window.
- R7: With N = 0 and the block enabled, exactly one drive is high on every cycle from the second enabled cycle onward.
- R8: The period, duty and dead-band shadows load only on the cycle where the timer equals P, or on any cycle while disabled. A change to the inputs at any other time does not affect the current cycle.
- R9: One clock after enable is low, both drives are low. The timer is then held at 0 and the delay counters are cleared.
- R10: The two drives are never high on the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable; low forces both drives off |
| period_i | input | CNT_W | Period value P; the timer wraps after reaching it |
| duty_i | input | CNT_W | Duty value D in timer counts |
| dband_i | input | DB_W | Dead-band delay N in clock cycles |
| pri_o | output | 1 | Primary high-side drive, active-high |
| cmp_o | output | 1 | Complementary drive, active-high |

## Verification
The bench builds the block with a 6-bit timer and the default 7-bit dead-band width. Periods of only a few dozen cycles keep each scenario short. The largest dead-band value, 127, is longer than any period the bench can program, so a count that suppresses both drives is within reach. The bench also sweeps short and long active windows against small dead-band values, duty values of zero and above the period, a duty change in the middle of a cycle, and disabling the block in the middle of a cycle.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;
    localparam int NUM_DRV = 2;
    localparam int DRV_PRI = 0;
    localparam int DRV_CMP = 1;
endpackage

// File: rtl/hbpwm_timebase.sv
module hbpwm_timebase #(
    parameter int CNT_W = 8,
    parameter int DB_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DB_W-1:0]  dband_i,
    output logic             pri_cond_o,
    output logic [DB_W-1:0]  dband_o
);
    typedef struct packed {
        logic [CNT_W-1:0] tmr;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic [DB_W-1:0]  db;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      match;
    logic      duty_full;

    always_comb begin
        st_d      = st_q;
        match     = (st_q.tmr == st_q.per);
        duty_full = (st_q.duty >= st_q.per);
        if (!enable_i) begin
            st_d.tmr  = '0;
            st_d.per  = period_i;
            st_d.duty = duty_i;
            st_d.db   = dband_i;
        end else if (match) begin
            st_d.tmr  = '0;
            st_d.per  = period_i;
            st_d.duty = duty_i;
            st_d.db   = dband_i;
        end else begin
            st_d.tmr  = st_q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pri_cond_o = (st_q.duty != '0) && ((st_q.tmr < st_q.duty) || duty_full);
    assign dband_o    = st_q.db;

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tmr <= st_q.per);                                          // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && st_q.tmr == st_q.per) |=> (st_q.tmr == '0));       // R2
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && st_q.tmr != st_q.per) |=>
            ($stable(st_q.duty) && $stable(st_q.db) && $stable(st_q.per))); // R8
endmodule

// File: rtl/hbpwm_deadband.sv
module hbpwm_deadband #(
    parameter int DB_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable_i,
    input  logic            cond_i,
    input  logic [DB_W-1:0] dband_i,
    output logic            drive_o
);
    typedef struct packed {
        logic [DB_W-1:0] cnt;
        logic            out;
    } db_state_t;

    db_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable_i || !cond_i) begin
            st_d.cnt = '0;
            st_d.out = 1'b0;
        end else if (st_q.cnt >= dband_i) begin
            st_d.out = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drive_o = st_q.out;

    AST_RISE_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.out) |-> $past(cond_i));                             // R5
    AST_DROP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !cond_i) |=> !st_q.out);                           // R4
    AST_ZERO_DB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && cond_i && dband_i == '0) |=> st_q.out);            // R7
endmodule

// File: rtl/hbridge_pwm.sv
module hbridge_pwm #(
    parameter int CNT_W = 8,
    parameter int DB_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DB_W-1:0]  dband_i,
    output logic             pri_o,
    output logic             cmp_o
);
    import hbpwm_pkg::*;

    logic                pri_cond;
    logic [DB_W-1:0]     db_sh;
    logic [NUM_DRV-1:0]  cond_vec;
    logic [NUM_DRV-1:0]  drv_vec;

    hbpwm_timebase #(.CNT_W(CNT_W), .DB_W(DB_W)) u_tbase (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .period_i   (period_i),
        .duty_i     (duty_i),
        .dband_i    (dband_i),
        .pri_cond_o (pri_cond),
        .dband_o    (db_sh)
    );

    assign cond_vec[DRV_PRI] = pri_cond;
    assign cond_vec[DRV_CMP] = ~pri_cond;

    for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
        hbpwm_deadband #(.DB_W(DB_W)) u_db (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable_i (enable_i),
            .cond_i   (cond_vec[g]),
            .dband_i  (db_sh),
            .drive_o  (drv_vec[g])
        );
    end

    assign pri_o = drv_vec[DRV_PRI];
    assign cmp_o = drv_vec[DRV_CMP];

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_o && cmp_o));                                             // R10
    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!pri_o && !cmp_o));                              // R9
endmodule

// File: tb/sim_hbridge_pwm.sv
module sim_hbridge_pwm;
    localparam int CLK_NS = 10;
    localparam int CW = 6;
    localparam int DW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [CW-1:0] per = '0;
    logic [CW-1:0] duty = '0;
    logic [DW-1:0] db = '0;
    logic          pri, cmp;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int m_tmr, m_per, m_duty, m_db, m_ca, m_cb;
    bit m_a, m_b;

    hbridge_pwm #(.CNT_W(CW), .DB_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(en), .period_i(per),
        .duty_i(duty), .dband_i(db), .pri_o(pri), .cmp_o(cmp)
    );

    always #(CLK_NS/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tmr = 0; m_per = 0; m_duty = 0; m_db = 0;
            m_ca = 0; m_cb = 0; m_a = 0; m_b = 0;
        end else begin
            bit cond;
            cond = (m_duty != 0) && ((m_tmr < m_duty) || (m_duty >= m_per));
            if (!en) begin
                m_a = 0; m_b = 0; m_ca = 0; m_cb = 0;
                m_tmr = 0;
                m_per = int'(per); m_duty = int'(duty); m_db = int'(db);
            end else begin
                if (!cond) begin m_a = 0; m_ca = 0; end
                else if (m_ca >= m_db) m_a = 1;
                else begin m_ca++; m_a = 0; end
                if (cond) begin m_b = 0; m_cb = 0; end
                else if (m_cb >= m_db) m_b = 1;
                else begin m_cb++; m_b = 0; end
                if (m_tmr == m_per) begin
                    m_tmr = 0;
                    m_per = int'(per); m_duty = int'(duty); m_db = int'(db);
                end else m_tmr++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(pri == m_a, {cur_req, " pri"}, int'(pri), int'(m_a));
            chk(cmp == m_b, {cur_req, " cmp"}, int'(cmp), int'(m_b));
            chk(!(pri && cmp), "R10", int'(pri && cmp), 0);
        end
    end

    task automatic setup(input int p, input int d, input int n, input string req);
        @(negedge clk);
        en = 0; per = CW'(p); duty = CW'(d); db = DW'(n); cur_req = req;
        @(negedge clk);
        en = 1;
    endtask

    task automatic count_high(input int cycles, output int np, output int nc);
        np = 0; nc = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pri) np++;
            if (cmp) nc++;
        end
    endtask

    initial begin
        #(CLK_NS*150000);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int np, nc;
        // R1: reset and disabled state
        repeat (3) @(negedge clk);
        chk(!pri && !cmp, "R1 in reset", int'(pri || cmp), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(!pri && !cmp, "R1 after reset", int'(pri || cmp), 0);

        // R7: zero dead-band, exact complement
        setup(9, 4, 0, "R7");
        @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk(pri ^ cmp, "R7 one drive high", int'(pri) + int'(cmp), 1);
        end
        // R2/R3: primary high D cycles of every P+1
        count_high(20, np, nc);
        chk(np == 8, "R2 primary count two cycles", np, 8);
        chk(nc == 12, "R4 complement count", nc, 12);

        // R5: dead-band delays rising edges
        setup(9, 5, 2, "R5");
        count_high(30, np, nc);
        chk(np == 9, "R5 primary after delay", np, 9);

        // R6: primary window shorter than the delay
        setup(20, 4, 6, "R6");
        count_high(42, np, nc);
        chk(np == 0, "R6 short window suppressed", np, 0);
        chk(nc > 0, "R6 long window passes", nc, 22);

        // R3: duty zero and duty above period
        setup(9, 0, 1, "R3");
        count_high(20, np, nc);
        chk(np == 0, "R3 zero duty", np, 0);
        setup(9, 12, 1, "R3");
        count_high(3, np, nc);
        count_high(20, np, nc);
        chk(np == 20 && nc == 0, "R3 full duty", np, 20);

        // R8: mid-cycle duty change has no effect on current cycle
        setup(15, 3, 0, "R8");
        repeat (6) @(negedge clk);
        duty = CW'(12);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!pri, "R8 old duty kept", int'(pri), 0);
        end
        repeat (40) @(negedge clk);

        // R9: disable mid-run
        cur_req = "R9";
        en = 0;
        @(negedge clk);
        chk(!pri && !cmp, "R9 disabled", int'(pri || cmp), 0);
        repeat (3) @(negedge clk);

        // R6: dead-band beyond the whole period suppresses both
        setup(9, 5, 127, "R6");
        count_high(40, np, nc);
        chk(np == 0 && nc == 0, "R6 max dead-band", np + nc, 0);

        // R5: other pattern with odd values
        setup(13, 9, 3, "R5");
        repeat (60) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule